// File: doc/BRIEF.md
# Four-Wide Rename Map Table

This block keeps, for every architectural register, the place where that register's newest value lives. The value is either in a reorder-buffer (ROB) slot, while a speculative producer is still in flight, or in the committed register file, once the value has retired. Every cycle a group of up to four micro-ops presents its source registers and its destination registers. The block returns where each source must be read from, and it hands each destination-bearing micro-op a fresh ROB index taken from the allocation port.

Dependencies inside one group are resolved in the same cycle. A source that names a register written by an older micro-op of the same group receives that micro-op's new ROB index. The retire port clears a mapping back to the committed file when the retiring ROB entry is still the register's newest producer. A flush sends every mapping back to the committed file at once. The ROB storage and the execution units lie outside the block. The bench stands in for them by driving the allocation base, the free count and the retire port. All rename results appear on registered outputs one cycle after the group is accepted.

Top module: `rat_rename4`

## Requirements
- R1: After reset, every architectural register maps to the committed file, and `out_vld` is 0.
- R2: A source register with no older writer in its group returns the table mapping. The location bit is 1 for a ROB slot and 0 for the committed file. The tag is the ROB index when the location bit is 1 and 0 when it is 0.
- R3: Micro-ops with `uop_vld` and `dst_vld` both set receive ROB indices in lane order, starting at `rob_base` and counting upward modulo the ROB depth. Lanes without a destination get `out_dst_vld`=0 and tag 0. `out_alloc_cnt` equals the number of indices handed out.
- R4: A source that names a register written by an older valid micro-op in the same group returns location 1 and the ROB index of the youngest such older writer.
- R5: When several micro-ops in one group write the same register, the table keeps the index of the youngest of them.
- R6: When `rob_free` is smaller than the number of destinations in the group, `ren_ready` is 0, the group produces no output and the table does not change. Otherwise `ren_ready` is 1 and a valid group produces output in the next cycle.
- R7: A retire of (register, index) reverts that register to the committed file only if the register currently maps to that same ROB index. Otherwise the retire has no effect.
- R8: A flush returns all mappings to the committed file in one cycle. A group presented in the flush cycle is refused: `ren_ready` is 0 and there is no output.
- R9: When a rename writes a register in the same cycle that a matching retire reverts it, the new rename mapping is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Return all mappings to the committed file |
| grp_vld | input | 1 | A rename group is presented |
| uop_vld | input | W | Per-lane micro-op valid |
| dst_vld | input | W | Per-lane destination present |
| dst_areg | input | W*AW | Per-lane destination register, lane 0 in the low bits |
| srca_areg | input | W*AW | Per-lane first source register |
| srcb_areg | input | W*AW | Per-lane second source register |
| rob_base | input | RW | Next free ROB index |
| rob_free | input | RW+1 | Number of free ROB entries |
| ren_ready | output | 1 | Group can be accepted this cycle |
| ret_vld | input | 1 | A ROB entry retires |
| ret_areg | input | AW | Destination register of the retiring entry |
| ret_tag | input | RW | ROB index of the retiring entry |
| out_vld | output | 1 | Registered rename result is valid |
| out_uop_vld | output | W | Lane valids of the result |
| out_dst_vld | output | W | Lanes that received a ROB index |
| out_dst_tag | output | W*RW | Allocated ROB indices |
| out_srca_rob | output | W | First source resides in the ROB |
| out_srca_tag | output | W*RW | First source ROB index |
| out_srcb_rob | output | W | Second source resides in the ROB |
| out_srcb_tag | output | W*RW | Second source ROB index |
| out_alloc_cnt | output | CW | Number of ROB indices consumed |

## Verification
The bench targets several cases that a faulty design would get wrong:
- A group that writes one register twice while later lanes read it. A design with the bypass priority reversed would hand out the older index.
- A retire that names a stale index. A design that ignores the index match would expose a value still in flight.
- Allocation that wraps past the last ROB slot. A design without the wrap would emit out-of-range indices.
- A group that needs one more entry than is free. A design with an off-by-one stall check would overrun the ROB.
- A retire that collides with a new rename of the same register, and a flush that coincides with a presented group. A wrong priority in either case would leave stale mappings.

// File: rtl/rat_pkg.sv
package rat_pkg;
  localparam int DEF_WIDTH = 4;
  localparam int DEF_ARCH  = 16;
  localparam int DEF_ROB   = 32;

  typedef enum logic {
    LOC_ARF = 1'b0,
    LOC_ROB = 1'b1
  } loc_e;
endpackage

// File: rtl/rat_alloc.sv
// Hands out ROB indices to destination-bearing lanes in lane order.
module rat_alloc #(
  parameter int W   = 4,
  parameter int ROB = 32,
  parameter int RW  = 5,
  parameter int CW  = 3
) (
  input  logic [W-1:0]    uop_vld,
  input  logic [W-1:0]    dst_vld,
  input  logic [RW-1:0]   rob_base,
  output logic [W-1:0]    eff_dst,
  output logic [W*RW-1:0] dst_tag,
  output logic [CW-1:0]   need
);
  logic [CW-1:0] cnt;
  logic [RW:0]   sum;

  always_comb begin
    cnt     = '0;
    sum     = '0;
    eff_dst = '0;
    dst_tag = '0;
    for (int k = 0; k < W; k++) begin
      eff_dst[k] = uop_vld[k] & dst_vld[k];
      sum = {1'b0, rob_base} + (RW+1)'(cnt);
      if (sum >= (RW+1)'(ROB)) sum = sum - (RW+1)'(ROB);
      if (eff_dst[k]) begin
        dst_tag[k*RW +: RW] = sum[RW-1:0];
        cnt = cnt + 1'b1;
      end
    end
    need = cnt;
  end
endmodule

// File: rtl/rat_bypass.sv
// Per-lane source lookup with override from older writers in the group.
module rat_bypass #(
  parameter int W  = 4,
  parameter int NA = 16,
  parameter int AW = 4,
  parameter int RW = 5
) (
  input  logic [W-1:0]    eff_dst,
  input  logic [W*AW-1:0] dst_areg,
  input  logic [W*RW-1:0] dst_tag,
  input  logic [NA-1:0]   map_rob,
  input  logic [NA*RW-1:0] map_tag,
  input  logic [W*AW-1:0] src_areg,
  output logic [W-1:0]    src_rob,
  output logic [W*RW-1:0] src_tag
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    logic [AW-1:0] s;
    logic          hit;
    logic [RW-1:0] tg;
    assign s = src_areg[i*AW +: AW];
    always_comb begin
      hit = map_rob[s];
      tg  = map_tag[int'(s)*RW +: RW];
      for (int j = 0; j < i; j++) begin
        if (eff_dst[j] && dst_areg[j*AW +: AW] == s) begin
          hit = rat_pkg::LOC_ROB;
          tg  = dst_tag[j*RW +: RW];
        end
      end
    end
    assign src_rob[i]          = hit;
    assign src_tag[i*RW +: RW] = hit ? tg : '0;
  end
endmodule

// File: rtl/rat_table.sv
// Mapping storage: flush, conditional retire revert, then rename writes.
module rat_table #(
  parameter int W  = 4,
  parameter int NA = 16,
  parameter int AW = 4,
  parameter int RW = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fire,
  input  logic [W-1:0]     eff_dst,
  input  logic [W*AW-1:0]  dst_areg,
  input  logic [W*RW-1:0]  dst_tag,
  input  logic             ret_vld,
  input  logic [AW-1:0]    ret_areg,
  input  logic [RW-1:0]    ret_tag,
  output logic [NA-1:0]    map_rob,
  output logic [NA*RW-1:0] map_tag
);
  logic [NA-1:0]    nxt_rob;
  logic [NA*RW-1:0] nxt_tag;

  always_comb begin
    nxt_rob = map_rob;
    nxt_tag = map_tag;
    for (int r = 0; r < NA; r++) begin
      if (ret_vld && map_rob[r] && ret_areg == AW'(r) &&
          map_tag[r*RW +: RW] == ret_tag)
        nxt_rob[r] = rat_pkg::LOC_ARF;
      if (fire) begin
        for (int j = 0; j < W; j++) begin
          if (eff_dst[j] && dst_areg[j*AW +: AW] == AW'(r)) begin
            nxt_rob[r]          = rat_pkg::LOC_ROB;
            nxt_tag[r*RW +: RW] = dst_tag[j*RW +: RW];
          end
        end
      end
      if (flush) nxt_rob[r] = rat_pkg::LOC_ARF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_rob <= '0;
      map_tag <= '0;
    end else begin
      map_rob <= nxt_rob;
      map_tag <= nxt_tag;
    end
  end
endmodule

// File: rtl/rat_rename4.sv
module rat_rename4 #(
  parameter int W   = rat_pkg::DEF_WIDTH,
  parameter int NA  = rat_pkg::DEF_ARCH,
  parameter int ROB = rat_pkg::DEF_ROB,
  localparam int AW = $clog2(NA),
  localparam int RW = $clog2(ROB),
  localparam int CW = $clog2(W+1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            grp_vld,
  input  logic [W-1:0]    uop_vld,
  input  logic [W-1:0]    dst_vld,
  input  logic [W*AW-1:0] dst_areg,
  input  logic [W*AW-1:0] srca_areg,
  input  logic [W*AW-1:0] srcb_areg,
  input  logic [RW-1:0]   rob_base,
  input  logic [RW:0]     rob_free,
  output logic            ren_ready,
  input  logic            ret_vld,
  input  logic [AW-1:0]   ret_areg,
  input  logic [RW-1:0]   ret_tag,
  output logic            out_vld,
  output logic [W-1:0]    out_uop_vld,
  output logic [W-1:0]    out_dst_vld,
  output logic [W*RW-1:0] out_dst_tag,
  output logic [W-1:0]    out_srca_rob,
  output logic [W*RW-1:0] out_srca_tag,
  output logic [W-1:0]    out_srcb_rob,
  output logic [W*RW-1:0] out_srcb_tag,
  output logic [CW-1:0]   out_alloc_cnt
);
  logic [W-1:0]     eff_dst;
  logic [W*RW-1:0]  dst_tag;
  logic [CW-1:0]    need;
  logic [NA-1:0]    map_rob;
  logic [NA*RW-1:0] map_tag;
  logic [W-1:0]     a_rob, b_rob;
  logic [W*RW-1:0]  a_tag, b_tag;
  logic             fire;

  rat_alloc #(.W(W), .ROB(ROB), .RW(RW), .CW(CW)) u_alloc (
    .uop_vld(uop_vld), .dst_vld(dst_vld), .rob_base(rob_base),
    .eff_dst(eff_dst), .dst_tag(dst_tag), .need(need)
  );

  assign ren_ready = !flush && ((RW+1)'(need) <= rob_free);
  assign fire      = grp_vld && ren_ready;

  rat_table #(.W(W), .NA(NA), .AW(AW), .RW(RW)) u_table (
    .clk(clk), .rst(rst), .flush(flush), .fire(fire),
    .eff_dst(eff_dst), .dst_areg(dst_areg), .dst_tag(dst_tag),
    .ret_vld(ret_vld), .ret_areg(ret_areg), .ret_tag(ret_tag),
    .map_rob(map_rob), .map_tag(map_tag)
  );

  rat_bypass #(.W(W), .NA(NA), .AW(AW), .RW(RW)) u_byp_a (
    .eff_dst(eff_dst), .dst_areg(dst_areg), .dst_tag(dst_tag),
    .map_rob(map_rob), .map_tag(map_tag), .src_areg(srca_areg),
    .src_rob(a_rob), .src_tag(a_tag)
  );

  rat_bypass #(.W(W), .NA(NA), .AW(AW), .RW(RW)) u_byp_b (
    .eff_dst(eff_dst), .dst_areg(dst_areg), .dst_tag(dst_tag),
    .map_rob(map_rob), .map_tag(map_tag), .src_areg(srcb_areg),
    .src_rob(b_rob), .src_tag(b_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld       <= 1'b0;
      out_uop_vld   <= '0;
      out_dst_vld   <= '0;
      out_dst_tag   <= '0;
      out_srca_rob  <= '0;
      out_srca_tag  <= '0;
      out_srcb_rob  <= '0;
      out_srcb_tag  <= '0;
      out_alloc_cnt <= '0;
    end else begin
      out_vld <= fire;
      if (fire) begin
        out_uop_vld   <= uop_vld;
        out_dst_vld   <= eff_dst;
        out_dst_tag   <= dst_tag;
        out_srca_rob  <= a_rob;
        out_srca_tag  <= a_tag;
        out_srcb_rob  <= b_rob;
        out_srcb_tag  <= b_tag;
        out_alloc_cnt <= need;
      end
    end
  end
endmodule

// File: rtl/rat_rename4_chk.sv
module rat_rename4_chk #(
  parameter int W  = 4,
  parameter int RW = 5,
  parameter int CW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            grp_vld,
  input logic            ren_ready,
  input logic [RW-1:0]   rob_base,
  input logic [RW:0]     rob_free,
  input logic            out_vld,
  input logic [W-1:0]    out_dst_vld,
  input logic [W*RW-1:0] out_dst_tag,
  input logic [CW-1:0]   out_alloc_cnt
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_vld); // R1
  AST_ALLOC_COUNT: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> out_alloc_cnt == CW'($countones(out_dst_vld))); // R3
  AST_FIRST_TAG: assert property (@(posedge clk) disable iff (rst)
    grp_vld && ren_ready |=> !out_dst_vld[0] || out_dst_tag[RW-1:0] == $past(rob_base)); // R3
  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (rst)
    grp_vld && !ren_ready |=> !out_vld); // R6
  AST_ACCEPT_OUT: assert property (@(posedge clk) disable iff (rst)
    grp_vld && ren_ready |=> out_vld); // R6
  AST_NO_OVERALLOC: assert property (@(posedge clk) disable iff (rst)
    grp_vld && ren_ready |=> (RW+1)'(out_alloc_cnt) <= $past(rob_free)); // R6
  AST_FLUSH_REFUSE: assert property (@(posedge clk) disable iff (rst)
    flush |-> !ren_ready); // R8
  AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_vld); // R8
endmodule

bind rat_rename4 rat_rename4_chk #(.W(W), .RW(RW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .grp_vld(grp_vld),
  .ren_ready(ren_ready), .rob_base(rob_base), .rob_free(rob_free),
  .out_vld(out_vld), .out_dst_vld(out_dst_vld), .out_dst_tag(out_dst_tag),
  .out_alloc_cnt(out_alloc_cnt)
);

// File: tb/rat_rename4_tb.sv
module rat_rename4_tb;
  localparam int W = 4, NA = 16, ROB = 32, AW = 4, RW = 5, CW = 3;

  logic clk = 0, rst = 1, flush = 0, grp_vld = 0;
  logic [W-1:0] uop_vld = '0, dst_vld = '0;
  logic [W*AW-1:0] dst_areg = '0, srca_areg = '0, srcb_areg = '0;
  logic [RW-1:0] rob_base = '0;
  logic [RW:0] rob_free = '0;
  logic ren_ready, ret_vld = 0;
  logic [AW-1:0] ret_areg = '0;
  logic [RW-1:0] ret_tag = '0;
  logic out_vld;
  logic [W-1:0] out_uop_vld, out_dst_vld, out_srca_rob, out_srcb_rob;
  logic [W*RW-1:0] out_dst_tag, out_srca_tag, out_srcb_tag;
  logic [CW-1:0] out_alloc_cnt;

  always #4 clk = ~clk;

  rat_rename4 u_dut (.*);

  typedef struct {
    string lbl;
    logic [W-1:0] uv, dv, arob, brob;
    logic [W*RW-1:0] dtag, atag, btag;
    logic [CW-1:0] cnt;
  } exp_t;
  exp_t q[$];

  int n_run = 0, n_fail = 0;
  logic m_rob [NA];
  logic [RW-1:0] m_tag [NA];

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic drive(input string lbl, input logic g, input logic [3:0] uv, input logic [3:0] dv,
                       input logic [15:0] dst, input logic [15:0] sa, input logic [15:0] sb,
                       input logic [4:0] base, input logic [5:0] free,
                       input logic rv, input logic [3:0] ra, input logic [4:0] rt, input logic fl);
    exp_t e;
    int cnt, s;
    logic [W-1:0] eff;
    logic rdy;
    @(negedge clk);
    grp_vld = g; uop_vld = uv; dst_vld = dv; dst_areg = dst;
    srca_areg = sa; srcb_areg = sb; rob_base = base; rob_free = free;
    ret_vld = rv; ret_areg = ra; ret_tag = rt; flush = fl;
    #1;
    cnt = 0; e.dtag = '0; e.lbl = lbl;
    for (int k = 0; k < W; k++) begin
      eff[k] = uv[k] & dv[k];
      s = (int'(base) + cnt) % ROB;
      if (eff[k]) begin e.dtag[k*RW +: RW] = RW'(s); cnt++; end
    end
    e.uv = uv; e.dv = eff; e.cnt = CW'(cnt);
    for (int i = 0; i < W; i++) begin
      logic [AW-1:0] a, b;
      logic ar, br;
      logic [RW-1:0] at, bt;
      a = sa[i*AW +: AW]; b = sb[i*AW +: AW];
      ar = m_rob[a]; at = m_tag[a]; br = m_rob[b]; bt = m_tag[b];
      for (int j = 0; j < i; j++) begin
        if (eff[j] && dst[j*AW +: AW] == a) begin ar = 1; at = e.dtag[j*RW +: RW]; end
        if (eff[j] && dst[j*AW +: AW] == b) begin br = 1; bt = e.dtag[j*RW +: RW]; end
      end
      e.arob[i] = ar; e.atag[i*RW +: RW] = ar ? at : '0;
      e.brob[i] = br; e.btag[i*RW +: RW] = br ? bt : '0;
    end
    rdy = !fl && (cnt <= int'(free));
    check({"R6 R8 ready ", lbl}, 32'(ren_ready), 32'(rdy));
    if (fl) begin
      for (int r = 0; r < NA; r++) m_rob[r] = 0;
    end else begin
      if (rv && m_rob[ra] && m_tag[ra] == rt) m_rob[ra] = 0;
      if (g && rdy)
        for (int j = 0; j < W; j++)
          if (eff[j]) begin m_rob[dst[j*AW +: AW]] = 1; m_tag[dst[j*AW +: AW]] = e.dtag[j*RW +: RW]; end
    end
    if (g && rdy) q.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle();
    drive("idle", 0, 4'h0, 4'h0, 16'h0, 16'h0, 16'h0, 5'd0, 6'd32, 0, 4'd0, 5'd0, 0);
  endtask

  task automatic read_all(input string lbl);
    drive(lbl, 1, 4'hF, 4'h0, 16'h0, 16'h3210, 16'h7654, 5'd0, 6'd0, 0, 4'd0, 5'd0, 0);
    drive(lbl, 1, 4'hF, 4'h0, 16'h0, 16'hBA98, 16'hFEDC, 5'd0, 6'd0, 0, 4'd0, 5'd0, 0);
  endtask

  always @(negedge clk) begin
    if (!rst && out_vld) begin
      if (q.size() == 0) check("R6 unexpected output", 32'(out_vld), 32'd0);
      else begin
        exp_t e;
        e = q.pop_front();
        check({"R3 uop_vld ", e.lbl}, 32'(out_uop_vld), 32'(e.uv));
        check({"R3 dst_vld ", e.lbl}, 32'(out_dst_vld), 32'(e.dv));
        check({"R3 dst_tag ", e.lbl}, 32'(out_dst_tag), 32'(e.dtag));
        check({"R3 alloc_cnt ", e.lbl}, 32'(out_alloc_cnt), 32'(e.cnt));
        check({"R2 R4 srca_rob ", e.lbl}, 32'(out_srca_rob), 32'(e.arob));
        check({"R2 R4 srca_tag ", e.lbl}, 32'(out_srca_tag), 32'(e.atag));
        check({"R2 R4 srcb_rob ", e.lbl}, 32'(out_srcb_rob), 32'(e.brob));
        check({"R2 R4 srcb_tag ", e.lbl}, 32'(out_srcb_tag), 32'(e.btag));
      end
    end
  end

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < NA; r++) begin m_rob[r] = 0; m_tag[r] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R1 out_vld after reset", 32'(out_vld), 32'd0);
    read_all("R1 reset map");
    // R4 R5: lanes 0 and 2 both write r1, lane 1 writes r2
    drive("R4 R5 bypass", 1, 4'hF, 4'b0111, 16'h0121, 16'h1215, 16'h2130, 5'd0, 6'd32, 0, 4'd0, 5'd0, 0);
    drive("R2 R5 table", 1, 4'hF, 4'h0, 16'h0, 16'h0021, 16'h3210, 5'd3, 6'd29, 0, 4'd0, 5'd0, 0);
    // R6: needs 4, only 3 free
    drive("R6 stall", 1, 4'hF, 4'hF, 16'h9876, 16'h0, 16'h0, 5'd3, 6'd3, 0, 4'd0, 5'd0, 0);
    idle();
    drive("R6 exact fit", 1, 4'hF, 4'b0011, 16'h00A9, 16'h0021, 16'h0987, 5'd3, 6'd2, 0, 4'd0, 5'd0, 0);
    read_all("R6 table kept");
    // R7: stale retire then matching retire
    drive("R7 stale retire", 0, 4'h0, 4'h0, 16'h0, 16'h0, 16'h0, 5'd0, 6'd0, 1, 4'd1, 5'd0, 0);
    read_all("R7 after stale");
    drive("R7 match retire", 0, 4'h0, 4'h0, 16'h0, 16'h0, 16'h0, 5'd0, 6'd0, 1, 4'd1, 5'd2, 0);
    read_all("R7 after match");
    // R3: wrap around, partial lane valids
    drive("R3 wrap", 1, 4'hF, 4'b1101, 16'h6504, 16'h6541, 16'h0A92, 5'd30, 6'd5, 0, 4'd0, 5'd0, 0);
    drive("R3 lane gaps", 1, 4'b0101, 4'hF, 16'hCBED, 16'hDDEE, 16'h4321, 5'd1, 6'd2, 0, 4'd0, 5'd0, 0);
    read_all("R3 table");
    // R9: retire of r2 index 1 collides with new write of r2
    drive("R9 collide", 1, 4'h1, 4'h1, 16'h0002, 16'h0002, 16'h0002, 5'd3, 6'd8, 1, 4'd2, 5'd1, 0);
    read_all("R9 table");
    // R8: flush with group presented
    drive("R8 flush", 1, 4'hF, 4'hF, 16'h3210, 16'h0, 16'h0, 5'd4, 6'd8, 0, 4'd0, 5'd0, 1);
    idle();
    read_all("R8 after flush");
    idle(); idle();
    check("R3 queue drained", 32'(q.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule